// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block holds one counting semaphore that several requesters share. Each requester has a request line and an operation bit. The operation is either an acquire, which takes one unit, or a release, which returns one unit. A round-robin arbiter serves one operation per cycle, so the counter never sees two operations interleave.

An acquire on a non-zero count takes a unit and is granted at once. An acquire on a zero count does not poll. The requester is parked in a hardware wait queue and holds its request line high until it is granted. A release either returns a unit to the count, or hands the unit straight to the oldest parked requester. In the hand-off case the count is left unchanged.

The count starts at a reset value that sets how many requesters can hold the semaphore at the same time. A release that would push the count above its ceiling is refused, and an error pulse flags it.

Top module: `sem_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, the count equals INIT_CNT (default 2), and no grant or error is driven while no request is pending.
- R2: An acquire (req_op bit = 0) picked on a non-zero count pulses that requester's grant bit in the same cycle, and the count is one lower on the next cycle.
- R3: An acquire picked on a zero count gives no grant and parks the requester. The count never goes below zero.
- R4: A release (req_op bit = 1) picked while nobody is parked and the count is below CNT_MAX (default 5) is granted in the same cycle, and the count is one higher on the next cycle.
- R5: A release picked while requesters are parked grants the releaser and the oldest parked requester in the same cycle, and leaves the count unchanged.
- R6: Parked requesters are woken in the order in which they parked.
- R7: At most one operation is accepted per cycle. Among eligible requesters, the winner is the first one at or after the index that follows the previous winner, searching upward with wrap-around. Index 0 is searched first after reset.
- R8: A release picked while the count equals CNT_MAX and nobody is parked is granted, pulses ovf_err in that cycle, and leaves the count unchanged.
- R9: A parked requester that holds its request line is not arbitrated again and gets no grant until a release wakes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | N_REQ | One request line per requester |
| req_op | input | N_REQ | Operation per requester: 0 = acquire, 1 = release |
| grant | output | N_REQ | One-cycle grant pulse per requester |
| ovf_err | output | 1 | Pulses when a release is refused at the ceiling |
| count | output | CNT_W | Current semaphore count |

## Verification
A release and a wake-up of a parked acquirer can happen in the same cycle, and the design must then raise two grant bits while holding the count.

The bench provokes this by parking two acquirers at a zero count and then issuing releases one at a time. It checks that each release produces a double grant and that the waiters are woken in the order they parked.

A second collision comes from four releases raised together. The bench expects one acceptance per cycle, in round-robin order, and a count that rises by one each cycle. Each cycle's expected grant vector, error bit and count are worked out ahead of time and queued for comparison.

// File: rtl/sem_pkg.sv
// Shared types for the counting semaphore unit.
// Assumes nothing beyond a single clock domain.
package sem_pkg;

    // Operation carried on a requester's req_op bit
    typedef enum logic {
        OP_ACQ = 1'b0,
        OP_REL = 1'b1
    } sem_op_e;

    // Action chosen for the operation picked this cycle
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TAKE,
        ACT_PARK,
        ACT_GIVE,
        ACT_WAKE,
        ACT_REJECT
    } sem_act_e;

endpackage

// File: rtl/sem_rr_arb.sv
// Round-robin picker: each cycle selects one asserted input, starting the
// search just above the previous winner and wrapping around.
// Assumes N >= 2; the winner register advances only on a valid pick.
module sem_rr_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          pick_valid,
    output logic [IW-1:0] pick_idx
);

    logic [IW-1:0] last_q;

    // Search upward from last winner + 1 for the first asserted input
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            if (!pick_valid && req[(int'(last_q) + k) % N]) begin
                pick_valid = 1'b1;
                pick_idx   = IW'((int'(last_q) + k) % N);
            end
        end
    end

    // Remember the winner; reset so that index 0 is searched first
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(N - 1);
        else if (pick_valid)
            last_q <= pick_idx;
    end

endmodule

// File: rtl/sem_wait_fifo.sv
// Ordered queue of parked requester indices.
// Assumes each requester parks at most once at a time, so N slots never
// overflow, and that pop is only requested when the queue is not empty.
module sem_wait_fifo #(
    parameter int N  = 4,
    parameter int IW = 2,
    localparam int PW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [IW-1:0] head_idx,
    output logic          empty
);

    logic [IW-1:0] slots [N];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] occ_q;

    assign head_idx = slots[rd_q];
    assign empty    = (occ_q == '0);

    // Store the pushed index at the write slot
    always_ff @(posedge clk) begin
        if (push)
            slots[wr_q] <= push_idx;
    end

    // Advance pointers with wrap-around and track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push)
                wr_q <= (wr_q == PW'(N - 1)) ? '0 : wr_q + 1'b1;
            if (pop)
                rd_q <= (rd_q == PW'(N - 1)) ? '0 : rd_q + 1'b1;
            if (push && !pop)
                occ_q <= occ_q + 1'b1;
            else if (pop && !push)
                occ_q <= occ_q - 1'b1;
        end
    end

endmodule

// File: rtl/sem_unit.sv
// Counting semaphore shared by N_REQ requesters. One operation per cycle is
// picked by a round-robin arbiter. An acquire on zero parks the requester in
// an ordered queue; a release hands its unit to the oldest parked requester,
// if any, otherwise raises the count unless it sits at CNT_MAX.
// Assumes a parked requester holds req_valid high with req_op = acquire until
// granted, and every requester drops its request after its grant pulse.
module sem_unit #(
    parameter int N_REQ    = 4,
    parameter int CNT_MAX  = 5,
    parameter int INIT_CNT = 2,
    localparam int IW    = $clog2(N_REQ),
    localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  req_valid,
    input  logic [N_REQ-1:0]  req_op,
    output logic [N_REQ-1:0]  grant,
    output logic              ovf_err,
    output logic [CNT_W-1:0]  count
);
    import sem_pkg::*;

    logic [N_REQ-1:0] parked_q;
    logic [N_REQ-1:0] eligible;
    logic             pick_valid;
    logic [IW-1:0]    pick_idx;
    logic [IW-1:0]    head_idx;
    logic             q_empty;
    sem_op_e          pick_op;
    sem_act_e         act;
    logic [CNT_W-1:0] count_q;

    assign eligible = req_valid & ~parked_q;
    assign count    = count_q;

    sem_rr_arb #(.N(N_REQ)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (eligible),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    sem_wait_fifo #(.N(N_REQ), .IW(IW)) u_waitq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (act == ACT_PARK),
        .push_idx (pick_idx),
        .pop      (act == ACT_WAKE),
        .head_idx (head_idx),
        .empty    (q_empty)
    );

    // Decide what the picked operation does against count and queue state
    always_comb begin
        pick_op = sem_op_e'(req_op[pick_idx]);
        act     = ACT_NONE;
        if (pick_valid) begin
            if (pick_op == OP_ACQ)
                act = (count_q != '0) ? ACT_TAKE : ACT_PARK;
            else if (!q_empty)
                act = ACT_WAKE;
            else if (count_q == CNT_W'(CNT_MAX))
                act = ACT_REJECT;
            else
                act = ACT_GIVE;
        end
    end

    // Drive grant pulses: the picked requester, plus the woken one on a hand-off
    always_comb begin
        grant = '0;
        if (act != ACT_NONE && act != ACT_PARK)
            grant[pick_idx] = 1'b1;
        if (act == ACT_WAKE)
            grant[head_idx] = 1'b1;
    end

    assign ovf_err = (act == ACT_REJECT);

    // Update the count: take lowers it, give raises it, others hold it
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= CNT_W'(INIT_CNT);
        else if (act == ACT_TAKE)
            count_q <= count_q - 1'b1;
        else if (act == ACT_GIVE)
            count_q <= count_q + 1'b1;
    end

    // One parked flag per requester: set on park, cleared when woken
    for (genvar i = 0; i < N_REQ; i++) begin : g_park
        always_ff @(posedge clk) begin
            if (!rst_n)
                parked_q[i] <= 1'b0;
            else if (act == ACT_PARK && pick_idx == IW'(i))
                parked_q[i] <= 1'b1;
            else if (act == ACT_WAKE && head_idx == IW'(i))
                parked_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/sem_unit_chk.sv
// Port-level property checker for sem_unit, attached with bind below.
// Assumes the requester behaviour stated in sem_unit's header.
module sem_unit_chk #(
    parameter int N_REQ   = 4,
    parameter int CNT_MAX = 5,
    parameter int CNT_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req_valid,
    input logic [N_REQ-1:0] req_op,
    input logic [N_REQ-1:0] grant,
    input logic             ovf_err,
    input logic [CNT_W-1:0] count
);

    logic acq_granted, rel_granted;
    assign acq_granted = |(grant & req_valid & ~req_op);
    assign rel_granted = |(grant & req_valid & req_op);

    assert_acq_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_granted && !rel_granted) |=> count == $past(count) - 1'b1);

    assert_no_take_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !rel_granted) |-> !acq_granted);

    assert_rel_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_granted && !acq_granted && !ovf_err) |=> count == $past(count) + 1'b1);

    assert_handoff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_granted && acq_granted) |=> $stable(count));

    assert_one_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant & req_valid & req_op) <= 1);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> $stable(count));

    assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(CNT_MAX));

endmodule

bind sem_unit sem_unit_chk #(.N_REQ(N_REQ), .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .grant     (grant),
    .ovf_err   (ovf_err),
    .count     (count)
);

// File: tb/sem_unit_test.sv
// Scoreboard bench: the driver queues the expected grant vector, error bit and
// count for every cycle it drives; the monitor compares them before the edge.
module sem_unit_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req_valid;
    logic [N-1:0] req_op;
    logic [N-1:0] grant;
    logic         ovf_err;
    logic [2:0]   count;

    typedef struct {
        logic [N-1:0] g;
        logic         e;
        int           cnt;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #5 clk = ~clk;

    sem_unit #(.N_REQ(N), .CNT_MAX(5), .INIT_CNT(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .grant     (grant),
        .ovf_err   (ovf_err),
        .count     (count)
    );

    // Driver: apply one cycle of requests and queue what must be seen
    task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] op,
                       input logic [N-1:0] g, input logic e, input int cnt,
                       input string tag);
        exp_t it;
        @(negedge clk);
        req_valid = v;
        req_op    = op;
        it.g = g; it.e = e; it.cnt = cnt; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare outputs midway between the drive and the next edge
    always @(negedge clk) begin
        #3;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (grant !== it.g || ovf_err !== it.e || int'(count) != it.cnt) begin
                n_fails++;
                $display("FAIL %s: grant=%b err=%b count=%0d expected grant=%b err=%b count=%0d",
                         it.tag, grant, ovf_err, count, it.g, it.e, it.cnt);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = '0; req_op = '0;
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 2, "R1 in reset");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 2, "R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        exp_q.push_back('{g: 4'b0000, e: 1'b0, cnt: 2, tag: "R1 after reset"});
        // R2: acquires on a non-zero count
        cyc(4'b0001, 4'b0000, 4'b0001, 1'b0, 2, "R2 acquire req0");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 1, "R2 count lowered");
        cyc(4'b0010, 4'b0000, 4'b0010, 1'b0, 1, "R2 acquire req1");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 0, "R2 count at zero");
        // R3: acquires on zero park
        cyc(4'b0100, 4'b0000, 4'b0000, 1'b0, 0, "R3 req2 parks");
        cyc(4'b1100, 4'b0000, 4'b0000, 1'b0, 0, "R3 req3 parks");
        cyc(4'b1100, 4'b0000, 4'b0000, 1'b0, 0, "R9 parked not regranted");
        // R5/R6: releases hand off to waiters in park order
        cyc(4'b1101, 4'b0001, 4'b0101, 1'b0, 0, "R5 release wakes req2");
        cyc(4'b1000, 4'b0000, 4'b0000, 1'b0, 0, "R5 count held");
        cyc(4'b1010, 4'b0010, 4'b1010, 1'b0, 0, "R6 release wakes req3");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 0, "R6 count held");
        // R7/R4: four simultaneous releases served round-robin
        cyc(4'b1111, 4'b1111, 4'b0100, 1'b0, 0, "R7 pick req2");
        cyc(4'b1011, 4'b1111, 4'b1000, 1'b0, 1, "R7 pick req3");
        cyc(4'b0011, 4'b1111, 4'b0001, 1'b0, 2, "R7 pick req0 wrap");
        cyc(4'b0010, 4'b1111, 4'b0010, 1'b0, 3, "R4 release req1");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 4, "R4 count raised");
        // R8: ceiling
        cyc(4'b0001, 4'b0001, 4'b0001, 1'b0, 4, "R4 release to ceiling");
        cyc(4'b0100, 4'b0100, 4'b0100, 1'b1, 5, "R8 release refused");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 5, "R8 count held");
        // R7: mixed acquire and release raised together
        cyc(4'b0011, 4'b0010, 4'b0001, 1'b0, 5, "R7 acquire req0 first");
        cyc(4'b0010, 4'b0010, 4'b0010, 1'b0, 4, "R7 release req1 next");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 5, "R4 count restored");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule